// File: doc/BRIEF.md
# Duty-Ceiling PWM Generator

This block drives a power switch at a fixed switching frequency from a digital sawtooth. A free-running counter climbs from zero to PERIOD-1 and wraps, so the PWM frequency is the system clock divided by PERIOD. With a 100 MHz clock, the default PERIOD of 3334 gives about 30 kHz. Values between roughly 2858 and 4000 cover 25 to 35 kHz.

Two thresholds shape each period. Both are measured against the same counter value. The first is the loop control word: a larger control word keeps the switch off longer, so a rising feedback value narrows the pulse. The second is a duty-ceiling word, given directly as the largest on-time in clock cycles. Each word produces its own off request, and the two requests are ORed. The switch therefore stays off for the longer of the two intervals, and its on-time is the smaller of (PERIOD - control) and the ceiling.

Both words are captured once per period, at the wrap, so a period never mixes old and new settings. A one-cycle strobe marks the first cycle of every period. The strobe is aligned with the drive output.

Top module: `dtpwm_top`

## Requirements
- R1: `start_o` is high for exactly one cycle in every PERIOD cycles, so consecutive strobes are PERIOD cycles apart.
- R2: Inside a period whose settings are control value c and ceiling d with d >= PERIOD, the drive output is high for PERIOD - c cycles. A larger c gives a narrower pulse.
- R3: The number of high drive cycles in a period never exceeds the ceiling d. When PERIOD - d > c, it equals d exactly.
- R4: Within a period, the drive is low from the strobe cycle for k = min(PERIOD, max(c, PERIOD - d)) cycles. It is then high for the rest of the period, forming one contiguous pulse that ends at the period end.
- R5: The control and ceiling inputs are captured only in the last cycle of a period. A change in the middle of a period leaves that period's pulse unchanged and takes effect from the next strobe.
- R6: A control value of 0 gives the largest allowed on-time, min(PERIOD, d). A control value of PERIOD or more gives a drive that stays low for the whole period.
- R7: While `rst` is high, `drive_o` and `start_o` are 0 in the cycle after each reset edge. The first full period after reset is all off, whatever the inputs are.
- R8: A ceiling of 0 forces the drive low for the whole period. A ceiling of PERIOD or more imposes no limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | CW | Loop control word, in off-cycles at the start of a period |
| dz_i | input | CW | Duty-ceiling word, the largest on-time in cycles |
| drive_o | output | 1 | Registered switch drive, 1 = switch on |
| start_o | output | 1 | Registered one-cycle period-start strobe |

## Verification
With PERIOD set to 16, the bench sweeps every control value from 0 to PERIOD+4 against a set of ceilings. The ceilings are zero, small, mid-range, just under PERIOD, PERIOD itself and above PERIOD. This set separates the control-limited case from the ceiling-limited case, shows the saturation at both ends, and shows the transition where the two off intervals are equal. Every measured period has its inputs changed halfway through. Each check therefore also shows that a mid-period change has no effect on the running pulse and does take effect in the next period. A reset in the middle of the sweep, followed by a look at the first period after it, checks that the block starts in the off state.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  // Counter width for a sawtooth of the given period (at least 1 bit).
  function automatic int unsigned saw_width(input int unsigned period);
    return (period > 2) ? $clog2(period) : 1;
  endfunction
endpackage

// File: rtl/dtpwm_saw.sv
module dtpwm_saw #(
  parameter int PERIOD = 3334,
  parameter int PW     = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          zero_o
);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  assign wrap_o = (cnt_o == LAST);
  assign zero_o = (cnt_o == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= LAST);
  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == LAST) |=> (cnt_o == '0));
endmodule

// File: rtl/dtpwm_sample.sv
module dtpwm_sample #(
  parameter int PERIOD = 3334,
  parameter int CW     = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap_i,
  input  logic [CW-1:0] ctrl_i,
  input  logic [CW-1:0] dz_i,
  output logic [CW-1:0] ctrl_q,
  output logic [CW-1:0] lim_q
);
  localparam logic [CW-1:0] PER_C = CW'(PERIOD);

  // Ceiling word -> off threshold on the shared sawtooth.
  logic [CW-1:0] lim_d;
  assign lim_d = (dz_i >= PER_C) ? '0 : (PER_C - dz_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '1;          // all ones >= PERIOD: fully off
      lim_q  <= '0;
    end else if (wrap_i) begin
      ctrl_q <= ctrl_i;
      lim_q  <= lim_d;
    end
  end

  assert_hold_midperiod_R5: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> ($stable(ctrl_q) && $stable(lim_q)));
endmodule

// File: rtl/dtpwm_merge.sv
module dtpwm_merge #(
  parameter int PW = 12,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] cnt_i,
  input  logic          zero_i,
  input  logic [CW-1:0] ctrl_q,
  input  logic [CW-1:0] lim_q,
  output logic          drive_o,
  output logic          start_o
);
  logic [CW-1:0] cnt_x;
  logic          off_loop, off_ceiling;

  assign cnt_x       = CW'(cnt_i);
  assign off_loop    = (cnt_x < ctrl_q);
  assign off_ceiling = (cnt_x < lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_o <= 1'b0;
      start_o <= 1'b0;
    end else begin
      drive_o <= !(off_loop || off_ceiling);
      start_o <= zero_i;
    end
  end

  assert_contiguous_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    drive_o |=> (drive_o || start_o));
  assert_reset_off_R7: assert property (@(posedge clk)
    rst |=> (!drive_o && !start_o));
endmodule

// File: rtl/dtpwm_top.sv
module dtpwm_top #(
  parameter int PERIOD = 3334,
  localparam int PW    = dtpwm_pkg::saw_width(PERIOD),
  localparam int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ctrl_i,
  input  logic [CW-1:0] dz_i,
  output logic          drive_o,
  output logic          start_o
);
  logic [PW-1:0] cnt;
  logic          wrap, zero;
  logic [CW-1:0] ctrl_q, lim_q;

  dtpwm_saw #(.PERIOD(PERIOD), .PW(PW)) u_saw (
    .clk(clk), .rst(rst), .cnt_o(cnt), .wrap_o(wrap), .zero_o(zero));

  dtpwm_sample #(.PERIOD(PERIOD), .CW(CW)) u_sample (
    .clk(clk), .rst(rst), .wrap_i(wrap), .ctrl_i(ctrl_i), .dz_i(dz_i),
    .ctrl_q(ctrl_q), .lim_q(lim_q));

  dtpwm_merge #(.PW(PW), .CW(CW)) u_merge (
    .clk(clk), .rst(rst), .cnt_i(cnt), .zero_i(zero),
    .ctrl_q(ctrl_q), .lim_q(lim_q), .drive_o(drive_o), .start_o(start_o));
endmodule

// File: tb/sim_dtpwm_top.sv
module sim_dtpwm_top;
  localparam int TCLK = 10;
  localparam int P    = 16;
  localparam int CW   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] ctrl_i = '0;
  logic [CW-1:0] dz_i = '0;
  logic drive_o, start_o;
  int checks = 0;
  int failures = 0;

  always #(TCLK/2) clk = ~clk;

  dtpwm_top #(.PERIOD(P)) u0 (
    .clk(clk), .rst(rst), .ctrl_i(ctrl_i), .dz_i(dz_i),
    .drive_o(drive_o), .start_o(start_o));

  function automatic int exp_off(input int c, input int d);
    int lim = (d >= P) ? 0 : P - d;
    int k = (c > lim) ? c : lim;
    return (k > P) ? P : k;
  endfunction

  // Entry: at a negedge where start_o == 1. Checks one period against an
  // expected off-count, changes inputs mid-period, ends on the next strobe.
  task automatic measure(input int k, input int nc, input int nd, input string tag);
    int bad = 0;
    int ons = 0;
    for (int p = 0; p < P; p++) begin
      if (drive_o !== (p >= k)) bad++;
      if (drive_o === 1'b1) ons++;
      if (p > 0 && start_o !== 1'b0) bad++;
      if (p == P/2) begin ctrl_i = CW'(nc); dz_i = CW'(nd); end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s R4 R5: on=%0d exp_on=%0d mismatches=%0d", tag, ons, P-k, bad);
    end
    checks++;
    if (start_o !== 1'b1) begin
      failures++;
      $display("FAIL R1: start_o=%b exp=1 after %0d cycles", start_o, P);
    end
  endtask

  task automatic sync_start();
    int n = 0;
    while (start_o !== 1'b1 && n < 4*P) begin @(negedge clk); n++; end
  endtask

  initial begin
    int pc, pd;
    int dzs[7] = '{0, 1, 5, 8, 15, 16, 21};
    repeat (3) @(negedge clk);
    checks++;
    if (drive_o !== 1'b0 || start_o !== 1'b0) begin
      failures++;
      $display("FAIL R7: drive=%b start=%b exp=0 0", drive_o, start_o);
    end
    ctrl_i = 0; dz_i = 21;
    rst = 1'b0;
    sync_start();
    // First period after reset is off (R7); load first setting mid-period.
    pc = 0; pd = dzs[0];
    measure(P, pc, pd, "R7");
    foreach (dzs[j]) begin
      for (int c = 0; c <= P + 4; c++) begin
        string tag;
        int nc = c, nd = dzs[j];
        if (j == 0 && c == 0) continue;
        if (pc >= P) tag = "R6";
        else if (pc == 0) tag = "R6 R3";
        else if (pd == 0 || pd >= P) tag = "R8 R2";
        else if (P - pd > pc) tag = "R3";
        else tag = "R2";
        measure(exp_off(pc, pd), nc, nd, tag);
        pc = nc; pd = nd;
      end
    end
    measure(exp_off(pc, pd), 3, 21, "R2");
    // Reset in mid-run.
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (drive_o !== 1'b0 || start_o !== 1'b0) begin
        failures++;
        $display("FAIL R7: in reset drive=%b start=%b exp=0 0", drive_o, start_o);
      end
      @(negedge clk);
    end
    rst = 1'b0;
    sync_start();
    measure(P, 2, 9, "R7");
    measure(exp_off(2, 9), 0, 4, "R3");
    measure(exp_off(0, 4), 0, 4, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, exp finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule